// File: doc/BRIEF.md
# Program Status Register Writer

This block keeps the processor's current status word and one saved status word, both 32 bits wide. It applies masked move-to-status writes to either of them. The operand comes from a register value or from an 8-bit immediate. The immediate is rotated right by twice a 4-bit rotation field. Two field-select inputs choose which bytes of the operand take part: one for the flags byte and one for the control byte.

Only three groups of bits can ever change:

- the condition flags, bits 31:28;
- the state bit, bit 5;
- the interrupt-disable and mode bits, bits 7:6 and 3:0.

A write to the current word may change the flags and the state bit in any mode. Its interrupt-disable and mode bits are left alone while the current mode is user mode, encoded 5'b10000. Bit 4 of the mode field is always 1 in both words.

When a write really changes the five mode bits of the current word, a single-cycle pulse tells the surrounding core that the mode changed. Either word can be read back as a packed 32-bit value through a select input.

Top module: `psr_writer`

## Requirements
- R1: After reset both status words read 0x000000D3, which is the privileged mode 5'b10011 with both interrupt-disable bits (7 and 6) set, and mode_chg is 0.
- R2: With wr_use_imm = 1 the operand is imm_field[7:0], zero-extended and rotated right by 2 × imm_field[11:8] (no rotation when that field is 0). With wr_use_imm = 0 the operand is reg_operand.
- R3: A current-word write with fld_flags = 1 copies operand bits 31:28 into the current word. Bits 27:24 do not change.
- R4: A current-word write with fld_ctrl = 1 always copies operand bit 5. It copies operand bits 7:6 and 3:0 only when the current mode bits 4:0 are not 5'b10000 (user). Bit 4 stays 1.
- R5: A write with both fld_flags and fld_ctrl at 0 changes neither word.
- R6: Bits 27:8 and bit 4 of the current word never change after reset.
- R7: A saved-word write (wr_to_saved = 1) merges the operand into the saved word under the selected byte mask, restricted to bits 31:28, 7:5 and 3:0. It forces bit 4 to 1, applies no user-mode gating and leaves the current word unchanged.
- R8: mode_chg is 1 for exactly the one clock that follows an edge at which the current word's bits 4:0 changed value. It is 0 otherwise, including for a write that leaves the mode the same.
- R9: rd_data shows the current word when rd_sel = 0 and the saved word when rd_sel = 1, combinationally.
- R10: While wr_valid = 0, neither word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Apply a write at this edge |
| wr_to_saved | input | 1 | 1: write the saved word; 0: write the current word |
| wr_use_imm | input | 1 | 1: operand from imm_field; 0: from reg_operand |
| fld_flags | input | 1 | Enable the flags byte (31:24) |
| fld_ctrl | input | 1 | Enable the control byte (7:0) |
| imm_field | input | 12 | [7:0] immediate value, [11:8] rotation count |
| reg_operand | input | 32 | Register operand |
| rd_sel | input | 1 | Read select: 0 current, 1 saved |
| rd_data | output | 32 | Packed value of the selected word |
| mode_chg | output | 1 | One-cycle pulse after a mode change |

## Verification
A wrong merge mask or a missing user-mode gate is visible on rd_data at the first sample after the offending write. The mirror model compares both words after every write, so such an error surfaces within one cycle. A mode-change pulse that is late, stretched or spurious is caught by checking mode_chg in the cycle after each write and again in the idle cycle that follows. Rotation errors appear as wrong flag or control bits, because the immediate writes go through the same byte masks.

// File: rtl/psr_writer_pkg.sv
package psr_writer_pkg;
    localparam int WORD_W  = 32;
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int MODE_W  = 5;
    localparam int FIELD_W = IMM_W + ROT_W;
    localparam int BYTES   = WORD_W / 8;

    localparam logic [WORD_W-1:0] FLAG_BITS  = 32'hF000_0000;
    localparam logic [WORD_W-1:0] STATE_BITS = 32'h0000_0020;
    localparam logic [WORD_W-1:0] PRIV_BITS  = 32'h0000_00CF;
    localparam logic [WORD_W-1:0] FIXED_ONE  = 32'h0000_0010;
    localparam logic [WORD_W-1:0] LEGAL_BITS = FLAG_BITS | STATE_BITS | PRIV_BITS;
    localparam logic [MODE_W-1:0] MODE_USER  = 5'b10000;

    typedef struct packed {
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] saved;
        logic              mode_chg;
    } psr_state_t;
endpackage

// File: rtl/psr_operand.sv
module psr_operand
    import psr_writer_pkg::*;
(
    input  logic               use_imm,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [WORD_W-1:0]  reg_operand,
    output logic [WORD_W-1:0]  operand
);
    localparam int AMT_W = ROT_W + 1;

    logic [WORD_W-1:0]   imm_ext;
    logic [2*WORD_W-1:0] doubled;
    logic [2*WORD_W-1:0] shifted;
    logic [AMT_W-1:0]    amount;

    always_comb begin
        imm_ext = {{(WORD_W-IMM_W){1'b0}}, imm_field[IMM_W-1:0]};
        amount  = {imm_field[FIELD_W-1:IMM_W], 1'b0};
        doubled = {imm_ext, imm_ext};
        shifted = doubled >> amount;
        operand = use_imm ? shifted[WORD_W-1:0] : reg_operand;
    end
endmodule

// File: rtl/psr_byte_mask.sv
module psr_byte_mask
    import psr_writer_pkg::*;
(
    input  logic              fld_flags,
    input  logic              fld_ctrl,
    output logic [WORD_W-1:0] mask
);
    logic [BYTES-1:0] byte_en;

    always_comb begin
        byte_en          = '0;
        byte_en[0]       = fld_ctrl;
        byte_en[BYTES-1] = fld_flags;
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign mask[8*b +: 8] = {8{byte_en[b]}};
    end
endmodule

// File: rtl/psr_merge.sv
module psr_merge
    import psr_writer_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] saved,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] cur_new,
    output logic [WORD_W-1:0] saved_new
);
    logic              in_user;
    logic [WORD_W-1:0] cur_mask;
    logic [WORD_W-1:0] sav_mask;

    always_comb begin
        in_user   = (cur[MODE_W-1:0] == MODE_USER);
        cur_mask  = mask & (FLAG_BITS | STATE_BITS);
        if (!in_user) begin
            cur_mask = cur_mask | (mask & PRIV_BITS);
        end
        sav_mask  = mask & LEGAL_BITS;
        cur_new   = (cur & ~cur_mask) | (operand & cur_mask) | FIXED_ONE;
        saved_new = (saved & ~sav_mask) | (operand & sav_mask) | FIXED_ONE;
    end
endmodule

// File: rtl/psr_writer.sv
module psr_writer
    import psr_writer_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic               wr_to_saved,
    input  logic               wr_use_imm,
    input  logic               fld_flags,
    input  logic               fld_ctrl,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [WORD_W-1:0]  reg_operand,
    input  logic               rd_sel,
    output logic [WORD_W-1:0]  rd_data,
    output logic               mode_chg
);
    localparam logic [WORD_W-1:0] RESET_WORD =
        {{(WORD_W-8){1'b0}}, 2'b11, 1'b0, RESET_MODE};

    psr_state_t st_d, st_q;

    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] cur_new;
    logic [WORD_W-1:0] saved_new;

    psr_operand u_operand (
        .use_imm     (wr_use_imm),
        .imm_field   (imm_field),
        .reg_operand (reg_operand),
        .operand     (operand)
    );

    psr_byte_mask u_mask (
        .fld_flags (fld_flags),
        .fld_ctrl  (fld_ctrl),
        .mask      (mask)
    );

    psr_merge u_merge (
        .cur       (st_q.cur),
        .saved     (st_q.saved),
        .operand   (operand),
        .mask      (mask),
        .cur_new   (cur_new),
        .saved_new (saved_new)
    );

    always_comb begin
        st_d = st_q;
        if (wr_valid) begin
            if (wr_to_saved) begin
                st_d.saved = saved_new;
            end else begin
                st_d.cur = cur_new;
            end
        end
        st_d.mode_chg = (st_d.cur[MODE_W-1:0] != st_q.cur[MODE_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur      <= RESET_WORD;
            st_q.saved    <= RESET_WORD;
            st_q.mode_chg <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = rd_sel ? st_q.saved : st_q.cur;
    assign mode_chg = st_q.mode_chg;
endmodule

// File: rtl/psr_writer_chk.sv
module psr_writer_chk
    import psr_writer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_to_saved,
    input logic              fld_flags,
    input logic              fld_ctrl,
    input logic [WORD_W-1:0] cur_q,
    input logic [WORD_W-1:0] saved_q,
    input logic              mode_chg
);
    assert_rsvd_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cur_q[27:8]) && $stable(cur_q[4]));

    assert_user_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_to_saved && cur_q[MODE_W-1:0] == MODE_USER)
        |=> $stable(cur_q[7:6]) && $stable(cur_q[3:0]));

    assert_pulse_real_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (cur_q[MODE_W-1:0] != $past(cur_q[MODE_W-1:0])));

    assert_pulse_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q[MODE_W-1:0] != $past(cur_q[MODE_W-1:0])) |-> mode_chg);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(cur_q) && $stable(saved_q));

    assert_no_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !fld_flags && !fld_ctrl) |=> $stable(cur_q) && $stable(saved_q));

    assert_saved_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_to_saved) |=> $stable(cur_q) && saved_q[4]);
endmodule

bind psr_writer psr_writer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_to_saved (wr_to_saved),
    .fld_flags   (fld_flags),
    .fld_ctrl    (fld_ctrl),
    .cur_q       (st_q.cur),
    .saved_q     (st_q.saved),
    .mode_chg    (mode_chg)
);

// File: tb/sim_psr_writer.sv
`timescale 1ns/1ps
module sim_psr_writer;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_to_saved, wr_use_imm, fld_flags, fld_ctrl, rd_sel;
    logic [11:0] imm_field;
    logic [31:0] reg_operand, rd_data;
    logic        mode_chg;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_cur, m_sav;

    always #HALF clk = ~clk;

    psr_writer u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_to_saved(wr_to_saved),
        .wr_use_imm(wr_use_imm), .fld_flags(fld_flags), .fld_ctrl(fld_ctrl),
        .imm_field(imm_field), .reg_operand(reg_operand), .rd_sel(rd_sel),
        .rd_data(rd_data), .mode_chg(mode_chg)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_operand(input logic imm, input logic [11:0] f,
                                                input logic [31:0] r);
        int sh;
        logic [31:0] v;
        if (!imm) return r;
        v  = {24'd0, f[7:0]};
        sh = 2 * int'(f[11:8]);
        if (sh == 0) return v;
        return (v >> sh) | (v << (32 - sh));
    endfunction

    task automatic read_both(input string tag);
        rd_sel = 1'b0; #1;
        check({tag, " cur R9"}, rd_data, m_cur);
        rd_sel = 1'b1; #1;
        check({tag, " saved R9"}, rd_data, m_sav);
        rd_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_valid = 0; wr_to_saved = 0; wr_use_imm = 0;
        fld_flags = 0; fld_ctrl = 0; imm_field = '0; reg_operand = '0; rd_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cur = 32'h0000_00D3;
        m_sav = 32'h0000_00D3;
    endtask

    // one write, then checks in the cycle after and an idle cycle
    task automatic do_write(input string tag, input logic sav, input logic imm,
                            input logic ff, input logic fc, input logic [11:0] f,
                            input logic [31:0] r);
        logic [31:0] op;
        logic [4:0]  old_mode;
        @(negedge clk);
        wr_valid = 1; wr_to_saved = sav; wr_use_imm = imm;
        fld_flags = ff; fld_ctrl = fc; imm_field = f; reg_operand = r;
        op = ref_operand(imm, f, r);
        old_mode = m_cur[4:0];
        if (sav) begin
            if (ff) m_sav[31:28] = op[31:28];
            if (fc) begin m_sav[7:5] = op[7:5]; m_sav[3:0] = op[3:0]; end
            m_sav[4] = 1'b1;
        end else begin
            if (ff) m_cur[31:28] = op[31:28];
            if (fc) begin
                m_cur[5] = op[5];
                if (m_cur[4:0] != 5'b10000) begin
                    m_cur[7:6] = op[7:6];
                    m_cur[3:0] = op[3:0];
                end
            end
        end
        @(negedge clk);
        wr_valid = 0;
        reg_operand = ~reg_operand;
        imm_field = ~imm_field;
        read_both(tag);
        check({tag, " pulse R8"}, {31'd0, mode_chg}, {31'd0, old_mode != m_cur[4:0]});
        @(negedge clk);
        check({tag, " pulse drop R8"}, {31'd0, mode_chg}, 32'd0);
        read_both({tag, " idle R10"});
    endtask

    initial begin
        #(2 * HALF * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        @(negedge clk);
        read_both("reset R1");
        check("reset pulse R1", {31'd0, mode_chg}, 32'd0);

        // R2 immediate corners: no rotation, rotate by 30, rotate by 8
        do_write("imm rot0 R2", 1'b0, 1'b1, 1'b1, 1'b0, 12'h0F5, 32'h0);
        do_write("imm rot30 R2 R3", 1'b0, 1'b1, 1'b1, 1'b0, 12'hFA5, 32'h0);
        do_write("imm rot8 R2 R3", 1'b0, 1'b1, 1'b1, 1'b0, 12'h4C0, 32'h0);
        // R3: flags only, attempt to set bits 27:24 ignored
        do_write("flags R3 R6", 1'b0, 1'b0, 1'b1, 1'b0, 12'h0, 32'h5FFF_FFFF);
        // R5: no field selected
        do_write("nofield R5", 1'b0, 1'b0, 1'b0, 1'b0, 12'h0, 32'hFFFF_FFFF);
        do_write("nofield saved R5", 1'b1, 1'b0, 1'b0, 1'b0, 12'h0, 32'hFFFF_FFFF);
        // R8: same mode rewritten, no pulse
        do_write("samemode R8", 1'b0, 1'b0, 1'b0, 1'b1, 12'h0, 32'h0000_0093);
        // R4: mode change to 11111 with bit 4 clear in operand
        do_write("ctrl R4 R8", 1'b0, 1'b0, 1'b0, 1'b1, 12'h0, 32'h0000_000F);
        // R7: saved with operand zero keeps bit 4
        do_write("saved R7", 1'b1, 1'b0, 1'b1, 1'b1, 12'h0, 32'h0000_0000);
        do_write("saved all R7", 1'b1, 1'b0, 1'b1, 1'b1, 12'h0, 32'hFFFF_FFFF);
        // R4: enter user, then privilege write ignored but state bit and flags work
        do_write("to user R4", 1'b0, 1'b0, 1'b0, 1'b1, 12'h0, 32'h0000_0010);
        do_write("user gate R4", 1'b0, 1'b0, 1'b1, 1'b1, 12'h0, 32'hA000_00F3);
        do_write("user saved R7", 1'b1, 1'b0, 1'b0, 1'b1, 12'h0, 32'h0000_0041);

        // random mix, reset every 40 writes to leave user mode
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            logic [11:0] fv;
            logic [3:0]  ctl;
            if (i % 40 == 0) begin
                do_reset();
                @(negedge clk);
                read_both("rand reset R1");
            end
            rv  = $urandom;
            fv  = 12'($urandom);
            ctl = 4'($urandom);
            if (ctl[3] && !ctl[2]) rv[4:0] = 5'b10000;
            do_write("rand R2 R3 R4 R7", ctl[0], ctl[1], ctl[2], ctl[3] | ctl[0], fv, rv);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule